// File: doc/BRIEF.md
# I/O Port Wait-State Sequencer

This block adds the stall cycles that a display controller imposes on a CPU's I/O port accesses when the CPU and the display share the same RAM. A port access starts with a one-cycle strobe. The block then latches a class for the 16-bit port address and steps through the four phases of the I/O cycle, one phase per clock. In each phase it reports how many wait T-states that phase should add.

A phase can add wait states only when the address class enables that phase. The number of wait states comes from the position within the video frame. That position is the frame cycle input plus a signed offset input, wrapped into one frame. Inside the active display area the amount follows a repeating eight-cycle ramp, and outside that area it is zero. A model-select input turns port contention off for the later gate-array machines. With contention off, the sequence ends after a single cycle and reports no phases.

Top module: `io_wait_sequencer`

## Requirements
- R1: After reset, busy_o, done_o and step_vld_o are 0 and wait_o is 0.
- R2: While the block is idle, start_i makes busy_o go high one cycle later. The block then issues exactly four step outputs on consecutive cycles, with phase_o counting 0, 1, 2, 3. done_o pulses for one cycle together with phase 3, and busy_o is low in that cycle. A start_i that arrives while busy_o is high is ignored.
- R3: The address class and the model select are captured in the cycle that start_i is accepted. Later changes to port_addr_i have no effect on the running sequence.
- R4: An address with bits [15:14] = 01 and bit 0 = 1 adds the frame-position amount on all four phases.
- R5: An address with bits [15:14] = 01 and bit 0 = 0 adds the amount on phases 0 and 1. Phases 2 and 3 report 0.
- R6: An address with bits [15:14] other than 01 and bit 0 = 1 reports 0 on every phase.
- R7: An address with bits [15:14] other than 01 and bit 0 = 0 adds the amount on phase 1 only.
- R8: Let r = position − FIRST_CONT. When r ≥ 0, r / LINE_LEN < 192 and r mod LINE_LEN < 128, the amount is 6, 5, 4, 3, 2, 1, 0, 0 for r mod 8 = 0 through 7.
- R9: The amount is 0 for positions before FIRST_CONT. It is also 0 for line columns of 128 or more and for lines of 192 or more.
- R10: The position is frame_pos_i + frame_ofs_i. When the sum reaches FRAME_LEN or more, FRAME_LEN is subtracted from it. When the sum is below 0, FRAME_LEN is added to it.
- R11: When late_model_i = 1 at start, no step is issued. done_o pulses on the cycle after busy_o rises, and busy_o clears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Port access start strobe |
| port_addr_i | input | 16 | Port address, sampled on start |
| frame_pos_i | input | POS_W (17) | Current frame cycle |
| frame_ofs_i | input | POS_W+1 (18) | Signed offset added to the frame cycle |
| late_model_i | input | 1 | 1 = later gate-array model, no port contention |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| step_vld_o | output | 1 | phase_o and wait_o are valid this cycle |
| phase_o | output | 2 | Index of the reported phase |
| wait_o | output | WAIT_W (3) | Wait T-states for the reported phase |

## Verification
The four address classes run at a frame position where the amount is 6. Because the amount is nonzero, each class's per-phase mask shows up directly in wait_o. The amount ramp is swept across one eight-cycle group and across the edges of the display window: the first contended cycle, column 128, line 192 and the last frame cycle. This separates the table values from the window gating. Offsets that carry the sum past the frame end and below zero both land on the first contended cycle, which confirms the wrap in each direction. Three further sequences check the control behaviour: one changes the address while busy, one sends a stray start while busy, and one selects the late model.

// File: rtl/iowait_pkg.sv
package iowait_pkg;

   // Encoding is {in_video_range, even_address}
   typedef enum logic [1:0] {
      CLS_FAR_ODD   = 2'b00,
      CLS_FAR_EVEN  = 2'b01,
      CLS_NEAR_ODD  = 2'b10,
      CLS_NEAR_EVEN = 2'b11
   } port_cls_e;

   localparam int unsigned N_PHASE = 4;

   // Bit i enables contention on phase i
   function automatic logic [N_PHASE-1:0] phase_mask(port_cls_e c);
      case (c)
         CLS_NEAR_ODD:  phase_mask = 4'b1111;
         CLS_NEAR_EVEN: phase_mask = 4'b0011;
         CLS_FAR_EVEN:  phase_mask = 4'b0010;
         default:       phase_mask = 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/port_classifier.sv
module port_classifier
   import iowait_pkg::*;
#(
   parameter int unsigned   ADDR_W      = 16,
   parameter logic [15:0]   RANGE_MASK  = 16'hC000,
   parameter logic [15:0]   RANGE_MATCH = 16'h4000
) (
   input  logic [ADDR_W-1:0] addr_i,
   output port_cls_e         cls_o
);

   logic near, even;

   always_comb begin
      near  = ((addr_i & ADDR_W'(RANGE_MASK)) == ADDR_W'(RANGE_MATCH));
      even  = ~addr_i[0];
      cls_o = port_cls_e'({near, even});
   end

endmodule

// File: rtl/frame_wrap.sv
module frame_wrap #(
   parameter int unsigned FRAME_LEN = 69888,
   parameter int unsigned POS_W     = $clog2(FRAME_LEN)
) (
   input  logic [POS_W-1:0]   pos_i,
   input  logic signed [POS_W:0] ofs_i,
   output logic [POS_W-1:0]   pos_o
);

   localparam int unsigned SW = POS_W + 2;
   localparam logic signed [SW-1:0] FL = SW'(FRAME_LEN);

   logic signed [SW-1:0] a, b, sum, adj;

   always_comb begin
      a   = {2'b00, pos_i};
      b   = {ofs_i[POS_W], ofs_i};
      sum = a + b;
      if (sum >= FL)
         adj = sum - FL;
      else if (sum < 0)
         adj = sum + FL;
      else
         adj = sum;
      pos_o = adj[POS_W-1:0];
   end

endmodule

// File: rtl/contention_lut.sv
module contention_lut #(
   parameter int unsigned FIRST_CONT = 14335,
   parameter int unsigned LINE_LEN   = 224,
   parameter int unsigned DISP_LINES = 192,
   parameter int unsigned DISP_TICKS = 128,
   parameter int unsigned POS_W      = 17,
   parameter int unsigned WAIT_W     = 3
) (
   input  logic [POS_W-1:0]  pos_i,
   output logic [WAIT_W-1:0] amt_o
);

   logic [POS_W-1:0] rel, line, col;
   logic [2:0]       grp;
   logic             in_win;

   always_comb begin
      rel    = pos_i - POS_W'(FIRST_CONT);
      line   = rel / POS_W'(LINE_LEN);
      col    = rel % POS_W'(LINE_LEN);
      grp    = rel[2:0];
      in_win = (pos_i >= POS_W'(FIRST_CONT)) &&
               (line < POS_W'(DISP_LINES)) &&
               (col  < POS_W'(DISP_TICKS));
      if (in_win && grp < 3'd6)
         amt_o = WAIT_W'(3'd6 - grp);
      else
         amt_o = '0;
   end

endmodule

// File: rtl/io_wait_sequencer.sv
module io_wait_sequencer
   import iowait_pkg::*;
#(
   parameter int unsigned FRAME_LEN  = 69888,
   parameter int unsigned LINE_LEN   = 224,
   parameter int unsigned FIRST_CONT = 14335,
   parameter int unsigned DISP_LINES = 192,
   parameter int unsigned DISP_TICKS = 128,
   parameter int unsigned WAIT_W     = 3,
   parameter int unsigned POS_W      = $clog2(FRAME_LEN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [15:0]          port_addr_i,
   input  logic [POS_W-1:0]     frame_pos_i,
   input  logic signed [POS_W:0] frame_ofs_i,
   input  logic                 late_model_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 step_vld_o,
   output logic [1:0]           phase_o,
   output logic [WAIT_W-1:0]    wait_o
);

   localparam int unsigned CNT_W = $clog2(N_PHASE + 1);

   // Elaboration-time parameter checks
   generate
      if (LINE_LEN % 8 != 0 || DISP_TICKS > LINE_LEN)
         $error("io_wait_sequencer: bad line geometry");
      if (FIRST_CONT + DISP_LINES * LINE_LEN > FRAME_LEN)
         $error("io_wait_sequencer: display window exceeds frame");
      if (WAIT_W < 3)
         $error("io_wait_sequencer: WAIT_W too small for amount 6");
   endgenerate

   port_cls_e          cls_now, cls_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               late_q;
   logic [POS_W-1:0]   pos_w;
   logic [WAIT_W-1:0]  amt;
   logic [1:0]         cur_phase;
   logic [N_PHASE-1:0] mask, sel;
   logic               apply;

   port_classifier #(.ADDR_W(16)) u_cls (
      .addr_i (port_addr_i),
      .cls_o  (cls_now)
   );

   frame_wrap #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_wrap (
      .pos_i (frame_pos_i),
      .ofs_i (frame_ofs_i),
      .pos_o (pos_w)
   );

   contention_lut #(
      .FIRST_CONT (FIRST_CONT),
      .LINE_LEN   (LINE_LEN),
      .DISP_LINES (DISP_LINES),
      .DISP_TICKS (DISP_TICKS),
      .POS_W      (POS_W),
      .WAIT_W     (WAIT_W)
   ) u_lut (
      .pos_i (pos_w),
      .amt_o (amt)
   );

   assign busy_o    = (cnt_q != '0);
   assign cur_phase = 2'(CNT_W'(N_PHASE) - cnt_q);
   assign mask      = phase_mask(cls_q);

   genvar gi;
   generate
      for (gi = 0; gi < N_PHASE; gi++) begin : g_sel
         assign sel[gi] = mask[gi] && (cur_phase == 2'(gi));
      end
   endgenerate

   assign apply = |sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         cls_q      <= CLS_FAR_ODD;
         late_q     <= 1'b0;
         done_o     <= 1'b0;
         step_vld_o <= 1'b0;
         phase_o    <= '0;
         wait_o     <= '0;
      end else begin
         done_o     <= 1'b0;
         step_vld_o <= 1'b0;
         wait_o     <= '0;
         if (cnt_q == '0) begin
            if (start_i) begin
               cnt_q  <= CNT_W'(N_PHASE);
               cls_q  <= cls_now;
               late_q <= late_model_i;
            end
         end else if (late_q) begin
            cnt_q  <= '0;
            done_o <= 1'b1;
         end else begin
            step_vld_o <= 1'b1;
            phase_o    <= cur_phase;
            wait_o     <= apply ? amt : '0;
            cnt_q      <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1))
               done_o <= 1'b1;
         end
      end
   end

   // R2
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R2
   start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R2
   phase_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_vld_o && phase_o != 2'd3) |=> (step_vld_o && phase_o == $past(phase_o) + 2'd1));

   // R3
   cls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(cls_q));

   // R5 R7
   even_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_vld_o && phase_o[1] && cls_q[0]) |-> (wait_o == '0));

   // R6
   far_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_vld_o && cls_q == CLS_FAR_ODD) |-> (wait_o == '0));

   // R10
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_w < POS_W'(FRAME_LEN));

   // R11
   late_nostep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && late_q) |=> (!step_vld_o && done_o));

endmodule

// File: tb/sim_io_wait_sequencer.sv
module sim_io_wait_sequencer;

   localparam int FL    = 69888;
   localparam int LL    = 224;
   localparam int FIRST = 14335;
   localparam int PW    = 17;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [15:0]       port_addr_i = '0;
   logic [PW-1:0]     frame_pos_i = '0;
   logic signed [PW:0] frame_ofs_i = '0;
   logic              late_model_i = 1'b0;
   logic              busy_o, done_o, step_vld_o;
   logic [1:0]        phase_o;
   logic [2:0]        wait_o;

   int n_chk = 0;
   int n_bad = 0;
   bit fin = 0;

   always #10 clk = ~clk;

   io_wait_sequencer u0 (
      .clk, .rst_n, .start_i, .port_addr_i, .frame_pos_i, .frame_ofs_i,
      .late_model_i, .busy_o, .done_o, .step_vld_o, .phase_o, .wait_o
   );

   task automatic check(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_amt(input int pos, input int ofs);
      int p, r, k;
      p = pos + ofs;
      if (p >= FL) p = p - FL;
      else if (p < 0) p = p + FL;
      if (p < FIRST) return 0;
      r = p - FIRST;
      if (r / LL >= 192) return 0;
      if (r % LL >= 128) return 0;
      k = r % 8;
      return (k < 6) ? 6 - k : 0;
   endfunction

   function automatic bit exp_on(input logic [15:0] a, input int p);
      bit near, odd;
      near = (a[15:14] == 2'b01);
      odd  = a[0];
      if (near && odd) return 1'b1;
      if (near && !odd) return (p < 2);
      if (!near && odd) return 1'b0;
      return (p == 1);
   endfunction

   // Runs one access; mode 1 = change address while busy, mode 2 = stray start while busy
   task automatic run_seq(input logic [15:0] a, input int pos, input int ofs,
                          input bit late, input int mode, input string tag);
      int amt;
      amt = exp_amt(pos, ofs);
      port_addr_i  = a;
      frame_pos_i  = PW'(pos);
      frame_ofs_i  = (PW+1)'(ofs);
      late_model_i = late;
      start_i      = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o, 1, {tag, " R2 busy after start"});
      if (mode == 1) begin
         port_addr_i  = ~a;
         late_model_i = ~late;
      end
      if (late) begin
         @(negedge clk);
         check(step_vld_o, 0, {tag, " R11 no step"});
         check(done_o, 1, {tag, " R11 done"});
         check(busy_o, 0, {tag, " R11 busy cleared"});
      end else begin
         for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            start_i = 1'b0;
            check(step_vld_o, 1, {tag, " R2 step valid"});
            check(phase_o, p, {tag, " R2 phase"});
            check(wait_o, exp_on(a, p) ? amt : 0, {tag, $sformatf(" wait phase %0d", p)});
            if (mode == 2 && p == 0) begin
               port_addr_i = 16'h0001;
               start_i     = 1'b1;
            end
         end
         check(done_o, 1, {tag, " R2 done with last phase"});
         check(busy_o, 0, {tag, " R2 busy low at end"});
      end
      @(negedge clk);
      check(done_o, 0, {tag, " R2 done is one pulse"});
      check(busy_o, 0, {tag, " R2 idle after sequence"});
      check(step_vld_o, 0, {tag, " R2 no extra step"});
      @(negedge clk);
   endtask

   task automatic t_reset();
      check(busy_o, 0, "R1 busy");
      check(done_o, 0, "R1 done");
      check(step_vld_o, 0, "R1 step_vld");
      check(wait_o, 0, "R1 wait");
   endtask

   task automatic t_classes();
      run_seq(16'h4001, FIRST, 0, 0, 0, "R4 near odd 4001");
      run_seq(16'h7FFF, FIRST, 0, 0, 0, "R4 near odd 7FFF");
      run_seq(16'h4000, FIRST, 0, 0, 0, "R5 near even 4000");
      run_seq(16'h00FF, FIRST, 0, 0, 0, "R6 far odd 00FF");
      run_seq(16'hC001, FIRST, 0, 0, 0, "R6 far odd C001");
      run_seq(16'h80FE, FIRST, 0, 0, 0, "R7 far even 80FE");
      run_seq(16'h3FFE, FIRST + 1, 0, 0, 0, "R7 far even 3FFE");
   endtask

   task automatic t_table();
      for (int k = 0; k < 8; k++)
         run_seq(16'h4001, FIRST + 224 * 5 + k, 0, 0, 0, $sformatf("R8 ramp %0d", k));
   endtask

   task automatic t_outside();
      run_seq(16'h4001, 100, 0, 0, 0, "R9 before window");
      run_seq(16'h4001, FIRST - 1, 0, 0, 0, "R9 just before first");
      run_seq(16'h4001, FIRST + 128, 0, 0, 0, "R9 column 128");
      run_seq(16'h4001, FIRST + 224, 0, 0, 0, "R8 line 1 start");
      run_seq(16'h4001, FIRST + 191 * 224, 0, 0, 0, "R8 line 191");
      run_seq(16'h4001, FIRST + 192 * 224, 0, 0, 0, "R9 line 192");
      run_seq(16'h4001, FL - 1, 0, 0, 0, "R9 last cycle");
   endtask

   task automatic t_wrap();
      run_seq(16'h4001, 69880, 14343, 0, 0, "R10 wrap high");
      run_seq(16'h4001, 10, -(FL - FIRST + 10), 0, 0, "R10 wrap low");
      run_seq(16'h4001, FIRST + 10, -8, 0, 0, "R10 negative no wrap");
   endtask

   task automatic t_latch();
      run_seq(16'h4001, FIRST, 0, 0, 1, "R3 address change ignored");
   endtask

   task automatic t_stray_start();
      run_seq(16'h4000, FIRST + 2, 0, 0, 2, "R2 start while busy ignored");
   endtask

   task automatic t_late();
      run_seq(16'h4001, FIRST, 0, 1, 0, "R11 late model");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_classes();
      t_table();
      t_outside();
      t_wrap();
      t_latch();
      t_stray_start();
      t_late();
      fin = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule